// File: doc/BRIEF.md
# Multi-Requester Pipelined Bus Arbiter

This block shares one pipelined Wishbone slave port among a parameterised number of requesters. Every requester drives its own cycle, strobe, write-enable, address, write data and byte-select lines. In return it gets an acknowledge, read data and a stall. Exactly one requester is the owner at any time. The owner's request lines pass straight through to the slave in the same cycle. The slave's acknowledge, read data and stall go back to the owner only.

Ownership is sticky. There is no separate idle arbitration state. While the owner holds its cycle line, it keeps the bus. Once the owner lowers its cycle line, the bus counts as idle. In that same cycle, the lowest-numbered requester that is raising its cycle line takes over. If nobody requests, the previous owner stays selected. A requester that opens transfers back to back therefore never loses a cycle to arbitration.

Top module: `bus_share_arbiter`

## Requirements
- R1: After reset, requester 0 is the owner. With every cycle line low and slave stall low, requester 0 sees stall low and all other requesters see stall high.
- R2: When the owner's cycle line is low, the lowest-index requester with its cycle line high becomes the owner in that same cycle. Its request appears on the slave port without a dead cycle.
- R3: While the owner holds its cycle line high, it keeps the grant, even when lower-index requesters raise their cycle lines.
- R4: The owner changes only in a cycle where the current owner's cycle line is low.
- R5: If no requester has its cycle line high, the last owner stays selected across any number of idle cycles.
- R6: The owner's stall output equals the slave stall. Every other requester's stall output is held at 1.
- R7: Acknowledge and read data go only to the owner. Every other requester sees acknowledge low and read data all zero.
- R8: The slave-side cycle, strobe, write-enable, address, write data and byte-select equal the owner's inputs in the same cycle, with no register on the path.
- R9: If the previous owner drops its cycle line and raises it again while no lower-index requester is requesting, its new transfer reaches the slave in the cycle it raises its cycle line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_cyc | input | NUM_REQ | Per-requester bus-cycle line |
| req_stb | input | NUM_REQ | Per-requester strobe |
| req_we | input | NUM_REQ | Per-requester write enable |
| req_adr | input | NUM_REQ*ADDR_W | Requester addresses, requester i at bits [i*ADDR_W +: ADDR_W] |
| req_wdat | input | NUM_REQ*DATA_W | Requester write data, packed the same way |
| req_sel | input | NUM_REQ*SEL_W | Requester byte selects, packed the same way |
| req_ack | output | NUM_REQ | Per-requester acknowledge |
| req_rdat | output | NUM_REQ*DATA_W | Per-requester read data |
| req_stall | output | NUM_REQ | Per-requester stall |
| slv_cyc | output | 1 | Bus-cycle line to the slave |
| slv_stb | output | 1 | Strobe to the slave |
| slv_we | output | 1 | Write enable to the slave |
| slv_adr | output | ADDR_W | Address to the slave |
| slv_wdat | output | DATA_W | Write data to the slave |
| slv_sel | output | SEL_W | Byte select to the slave |
| slv_ack | input | 1 | Acknowledge from the slave |
| slv_rdat | input | DATA_W | Read data from the slave |
| slv_stall | input | 1 | Stall from the slave |

## Verification
The only internal state is the owner index. A wrong owner becomes visible at the ports in the same cycle as any combinational output. The stall pattern across requesters shows the owner even on an idle bus. The slave address shows it as soon as anyone requests. The bench uses distinct addresses and stall patterns for each requester, so a stale or wrongly chosen owner shows up in the first sample after the faulty clock edge. A grant lost during an open cycle, or a grant that does not stick across idle periods, is caught one clock after the edge that caused it.

// File: rtl/bus_share_pkg.sv
package bus_share_pkg;
   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/bus_share_owner.sv
module bus_share_owner
   import bus_share_pkg::*;
#(
   parameter int NUM_REQ = 3,
   localparam int IDX_W  = idx_width(NUM_REQ)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_REQ-1:0] cyc_in,
   output logic [IDX_W-1:0]   grant_idx
);
   generate
      if (NUM_REQ == 1) begin : g_single
         assign grant_idx = '0;
      end else begin : g_multi
         logic [IDX_W-1:0] owner_q;
         logic [IDX_W-1:0] lowest_idx;
         logic             owner_busy;

         assign owner_busy = cyc_in[owner_q];

         always_comb begin
            lowest_idx = owner_q;
            for (int i = NUM_REQ - 1; i >= 0; i--) begin
               if (cyc_in[i]) lowest_idx = IDX_W'(i);
            end
         end

         assign grant_idx = owner_busy ? owner_q : lowest_idx;

         always_ff @(posedge clk) begin
            if (rst) owner_q <= '0;
            else     owner_q <= grant_idx;
         end
      end
   endgenerate
endmodule

// File: rtl/bus_share_fwd.sv
module bus_share_fwd
   import bus_share_pkg::*;
#(
   parameter int NUM_REQ = 3,
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   localparam int SEL_W  = DATA_W / 8,
   localparam int IDX_W  = idx_width(NUM_REQ)
) (
   input  logic [IDX_W-1:0]          grant_idx,
   input  logic [NUM_REQ-1:0]        req_cyc,
   input  logic [NUM_REQ-1:0]        req_stb,
   input  logic [NUM_REQ-1:0]        req_we,
   input  logic [NUM_REQ*ADDR_W-1:0] req_adr,
   input  logic [NUM_REQ*DATA_W-1:0] req_wdat,
   input  logic [NUM_REQ*SEL_W-1:0]  req_sel,
   output logic                      slv_cyc,
   output logic                      slv_stb,
   output logic                      slv_we,
   output logic [ADDR_W-1:0]         slv_adr,
   output logic [DATA_W-1:0]         slv_wdat,
   output logic [SEL_W-1:0]          slv_sel
);
   assign slv_cyc  = req_cyc[grant_idx];
   assign slv_stb  = req_stb[grant_idx];
   assign slv_we   = req_we[grant_idx];
   assign slv_adr  = req_adr[grant_idx*ADDR_W +: ADDR_W];
   assign slv_wdat = req_wdat[grant_idx*DATA_W +: DATA_W];
   assign slv_sel  = req_sel[grant_idx*SEL_W +: SEL_W];
endmodule

// File: rtl/bus_share_resp.sv
module bus_share_resp
   import bus_share_pkg::*;
#(
   parameter int NUM_REQ = 3,
   parameter int DATA_W  = 32,
   localparam int IDX_W  = idx_width(NUM_REQ)
) (
   input  logic [IDX_W-1:0]          grant_idx,
   input  logic                      slv_ack,
   input  logic [DATA_W-1:0]         slv_rdat,
   input  logic                      slv_stall,
   output logic [NUM_REQ-1:0]        req_ack,
   output logic [NUM_REQ*DATA_W-1:0] req_rdat,
   output logic [NUM_REQ-1:0]        req_stall
);
   for (genvar i = 0; i < NUM_REQ; i++) begin : g_lane
      logic is_owner;
      assign is_owner     = (grant_idx == IDX_W'(i));
      assign req_ack[i]   = is_owner & slv_ack;
      assign req_stall[i] = is_owner ? slv_stall : 1'b1;
      assign req_rdat[i*DATA_W +: DATA_W] = is_owner ? slv_rdat : '0;
   end
endmodule

// File: rtl/bus_share_arbiter.sv
module bus_share_arbiter
   import bus_share_pkg::*;
#(
   parameter int NUM_REQ = 3,
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   localparam int SEL_W  = DATA_W / 8,
   localparam int IDX_W  = idx_width(NUM_REQ)
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic [NUM_REQ-1:0]        req_cyc,
   input  logic [NUM_REQ-1:0]        req_stb,
   input  logic [NUM_REQ-1:0]        req_we,
   input  logic [NUM_REQ*ADDR_W-1:0] req_adr,
   input  logic [NUM_REQ*DATA_W-1:0] req_wdat,
   input  logic [NUM_REQ*SEL_W-1:0]  req_sel,
   output logic [NUM_REQ-1:0]        req_ack,
   output logic [NUM_REQ*DATA_W-1:0] req_rdat,
   output logic [NUM_REQ-1:0]        req_stall,
   output logic                      slv_cyc,
   output logic                      slv_stb,
   output logic                      slv_we,
   output logic [ADDR_W-1:0]         slv_adr,
   output logic [DATA_W-1:0]         slv_wdat,
   output logic [SEL_W-1:0]          slv_sel,
   input  logic                      slv_ack,
   input  logic [DATA_W-1:0]         slv_rdat,
   input  logic                      slv_stall
);
   initial begin
      if (NUM_REQ < 1)     $error("NUM_REQ must be at least 1");
      if (ADDR_W < 1)      $error("ADDR_W must be at least 1");
      if (DATA_W % 8 != 0) $error("DATA_W must be a multiple of 8");
   end

   logic [IDX_W-1:0] grant_idx;

   bus_share_owner #(.NUM_REQ(NUM_REQ)) owner_i (
      .clk(clk), .rst(rst), .cyc_in(req_cyc), .grant_idx(grant_idx)
   );

   bus_share_fwd #(.NUM_REQ(NUM_REQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) fwd_i (
      .grant_idx(grant_idx),
      .req_cyc(req_cyc), .req_stb(req_stb), .req_we(req_we),
      .req_adr(req_adr), .req_wdat(req_wdat), .req_sel(req_sel),
      .slv_cyc(slv_cyc), .slv_stb(slv_stb), .slv_we(slv_we),
      .slv_adr(slv_adr), .slv_wdat(slv_wdat), .slv_sel(slv_sel)
   );

   bus_share_resp #(.NUM_REQ(NUM_REQ), .DATA_W(DATA_W)) resp_i (
      .grant_idx(grant_idx),
      .slv_ack(slv_ack), .slv_rdat(slv_rdat), .slv_stall(slv_stall),
      .req_ack(req_ack), .req_rdat(req_rdat), .req_stall(req_stall)
   );
endmodule

// File: rtl/bus_share_checker.sv
module bus_share_checker
   import bus_share_pkg::*;
#(
   parameter int NUM_REQ = 3,
   localparam int IDX_W  = idx_width(NUM_REQ)
) (
   input logic               clk,
   input logic               rst,
   input logic [NUM_REQ-1:0] req_cyc,
   input logic [NUM_REQ-1:0] req_ack,
   input logic [NUM_REQ-1:0] req_stall,
   input logic               slv_cyc,
   input logic               slv_ack,
   input logic [IDX_W-1:0]   grant_idx
);
   AST_STALL_ONE_OWNER: assert property (@(posedge clk) disable iff (rst)
      $countones(~req_stall) <= 1); // R6

   AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
      $onehot0(req_ack) && ((|req_ack) == slv_ack)); // R7

   AST_IDLE_MEANS_NO_REQ: assert property (@(posedge clk) disable iff (rst)
      !slv_cyc |-> (req_cyc == '0)); // R2

   AST_GRANT_HELD: assert property (@(posedge clk) disable iff (rst)
      slv_cyc |=> (req_cyc[$past(grant_idx)] -> (grant_idx == $past(grant_idx)))); // R3

   AST_STICKY_IDLE: assert property (@(posedge clk) disable iff (rst)
      !slv_cyc |=> ((req_cyc == '0) -> $stable(grant_idx))); // R5
endmodule

bind bus_share_arbiter bus_share_checker #(.NUM_REQ(NUM_REQ)) chk_i (
   .clk(clk), .rst(rst), .req_cyc(req_cyc), .req_ack(req_ack),
   .req_stall(req_stall), .slv_cyc(slv_cyc), .slv_ack(slv_ack),
   .grant_idx(grant_idx)
);

// File: tb/bus_share_arbiter_tb.sv
module bus_share_arbiter_tb_top;
   localparam int N  = 3;
   localparam int AW = 32;
   localparam int DW = 32;
   localparam int SW = DW / 8;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [N-1:0]    req_cyc = '0, req_stb = '0, req_we = '0;
   logic [N*AW-1:0] req_adr;
   logic [N*DW-1:0] req_wdat;
   logic [N*SW-1:0] req_sel;
   logic [N-1:0]    req_ack, req_stall;
   logic [N*DW-1:0] req_rdat;
   logic slv_cyc, slv_stb, slv_we;
   logic [AW-1:0] slv_adr;
   logic [DW-1:0] slv_wdat;
   logic [SW-1:0] slv_sel;
   logic slv_ack = 1'b0, slv_stall = 1'b0;
   logic [DW-1:0] slv_rdat = '0;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   bus_share_arbiter #(.NUM_REQ(N), .ADDR_W(AW), .DATA_W(DW)) dut_i (
      .clk(clk), .rst(rst),
      .req_cyc(req_cyc), .req_stb(req_stb), .req_we(req_we),
      .req_adr(req_adr), .req_wdat(req_wdat), .req_sel(req_sel),
      .req_ack(req_ack), .req_rdat(req_rdat), .req_stall(req_stall),
      .slv_cyc(slv_cyc), .slv_stb(slv_stb), .slv_we(slv_we),
      .slv_adr(slv_adr), .slv_wdat(slv_wdat), .slv_sel(slv_sel),
      .slv_ack(slv_ack), .slv_rdat(slv_rdat), .slv_stall(slv_stall)
   );

   function automatic logic [AW-1:0] adr_of(int i);
      return 32'h1000_0000 + 32'(i * 16);
   endfunction

   initial begin
      for (int i = 0; i < N; i++) begin
         req_adr[i*AW +: AW]  = adr_of(i);
         req_wdat[i*DW +: DW] = 32'hD0D0_0000 + 32'(i);
         req_sel[i*SW +: SW]  = SW'(i + 1);
         req_we[i]            = i[0];
      end
   end

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic drive(logic [N-1:0] cyc);
      @(negedge clk);
      req_cyc = cyc;
      req_stb = cyc;
      #1;
   endtask

   task automatic t_reset();
      rst = 1'b1;
      drive('0);
      @(negedge clk);
      rst = 1'b0;
      #1;
      check("R1 idle stall pattern", 64'(req_stall), 64'(3'b110));
      check("R1 no ack", 64'(req_ack), 64'h0);
   endtask

   task automatic t_lowest();
      drive(3'b110);
      check("R2 lowest requester address", 64'(slv_adr), 64'(adr_of(1)));
      check("R2 slave cyc", 64'(slv_cyc), 64'h1);
      check("R8 write data", 64'(slv_wdat), 64'h00000000D0D00001);
      check("R8 byte select", 64'(slv_sel), 64'h2);
      check("R8 write enable", 64'(slv_we), 64'h1);
      slv_stall = 1'b1; #1;
      check("R6 stall high everywhere", 64'(req_stall), 64'(3'b111));
      slv_stall = 1'b0; #1;
      check("R6 owner stall follows slave", 64'(req_stall), 64'(3'b101));
   endtask

   task automatic t_hold();
      drive(3'b111);
      check("R3 owner kept against lower index", 64'(slv_adr), 64'(adr_of(1)));
      @(negedge clk); #1;
      check("R3 owner kept next cycle", 64'(slv_adr), 64'(adr_of(1)));
      slv_ack = 1'b1; slv_rdat = 32'hCAFE_F00D; #1;
      check("R7 ack only owner", 64'(req_ack), 64'(3'b010));
      check("R7 owner read data", 64'(req_rdat[1*DW +: DW]), 64'hCAFEF00D);
      check("R7 other read data zero", 64'(req_rdat[0 +: DW]), 64'h0);
      check("R7 third read data zero", 64'(req_rdat[2*DW +: DW]), 64'h0);
      slv_ack = 1'b0; slv_rdat = '0;
   endtask

   task automatic t_switch();
      drive(3'b101);
      check("R4 switch on owner release", 64'(slv_adr), 64'(adr_of(0)));
      check("R4 new stall pattern", 64'(req_stall), 64'(3'b110));
   endtask

   task automatic t_sticky();
      drive(3'b100);
      check("R2 requester 2 takes idle bus", 64'(slv_adr), 64'(adr_of(2)));
      drive(3'b000);
      check("R5 idle keeps owner 2", 64'(req_stall), 64'(3'b011));
      repeat (3) @(negedge clk);
      #1;
      check("R5 still owner 2 after idle", 64'(req_stall), 64'(3'b011));
      check("R5 slave idle", 64'(slv_cyc), 64'h0);
   endtask

   task automatic t_back_to_back();
      drive(3'b100);
      check("R9 re-raise forwarded at once", 64'(slv_cyc), 64'h1);
      check("R9 re-raise address", 64'(slv_adr), 64'(adr_of(2)));
      drive(3'b000);
      drive(3'b100);
      check("R9 second burst no dead cycle", 64'(slv_cyc), 64'h1);
      check("R8 strobe passes", 64'(slv_stb), 64'h1);
      drive(3'b000);
   endtask

   initial begin
      t_reset();
      t_lowest();
      t_hold();
      t_switch();
      t_sticky();
      t_back_to_back();
      t_reset();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule